// File: doc/BRIEF.md
# Cascadable Codec Serial Port

This block is the full-duplex synchronous serial port of a codec front end. It exchanges 16-bit frames with a DSP over a serial clock, a frame-sync line and a data line in each direction. One shift register does the work for both directions: received bits enter at the bottom while transmitted bits leave from the top. Each accepted ADC sample overwrites the register and starts an output frame.

Received frames are decoded according to a mode held in configuration register 0. In control mode they write or read an eight-entry bank of 8-bit configuration registers. In data mode every frame is a DAC word, and each output frame carries the ADC sample. In mixed mode the top bit of each frame tells control frames apart from data frames, so samples shrink to 15 bits.

The ADC side is a valid/ready sink. `adc_ready` rises on the first clock edge after reset and then stays high, because an output sample event cannot be deferred. The DAC side is a valid/ready source. `dac_valid` stays high with stable data until `dac_ready` is seen, and a newer DAC frame replaces a word that has not been taken. The configuration port is a plain register access port.

Top module: `codec_serial_port`

## Requirements
- R1: Reset clears all eight configuration registers, which selects control mode. After reset `fs_out`, `sd_out` and `dac_valid` are 0, and `adc_ready` is 1 from the first rising edge after reset is released.
- R2: A frame starts when `fs_in` is high at a rising `clk` edge. That edge samples bit 15, and the next 15 edges sample bits 14 down to 0, MSB first. The frame takes effect on the edge that samples bit 0.
- R3: In control mode, a frame with bit 15 = 1 and bit 14 = 0 writes bits 7:0 into the register addressed by bits 10:8. A frame with bit 15 = 0 has no effect on the registers or on the DAC output.
- R4: A control frame with bit 15 = 1 and bit 14 = 1 requests a read. The next output frame is then 2'b11, 3'b000, the 3-bit address and the addressed register's value at that sample event, in any mode. In control mode with no read pending, the output frame is 16'h0000.
- R5: Bits 1:0 of register 0 pick the mode: bit 0 = 0 selects control, 2'b01 selects data and 2'b11 selects mixed. A change takes effect from the next frame.
- R6: In data mode, every received frame sets `dac_data` to the full 16-bit word. Each output frame is `adc_data` unchanged.
- R7: In mixed mode, a frame with bit 15 = 0 sets `dac_data` to bits 14:0 followed by a 0. A frame with bit 15 = 1 is decoded as a control frame. Output frames are a 0 followed by `adc_data[15:1]`.
- R8: An ADC transfer loads the shift register. `fs_out` is high for exactly the one cycle after the transfer, during which `sd_out` shows bit 15. Each later rising edge moves the next lower bit onto `sd_out`.
- R9: An ADC transfer discards any partly received frame, and an `fs_in` on that same edge is ignored. A frame whose `fs_in` is on the edge after the transfer is received intact while the sample shifts out.
- R10: `dac_valid` and `dac_data` hold until `dac_ready` is high at a rising edge. A new DAC frame replaces a word that has not been taken.
- R11: `cfg_wr` writes `cfg_wdata` into register `cfg_addr`, and `cfg_rdata` always shows register `cfg_addr`. When a serial write to the same register completes on the same edge, the serial write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| fs_in | input | 1 | Receive frame sync, one cycle wide |
| sd_in | input | 1 | Receive serial data |
| fs_out | output | 1 | Transmit frame sync |
| sd_out | output | 1 | Transmit serial data |
| adc_valid | input | 1 | ADC sample offered |
| adc_ready | output | 1 | ADC sample accepted |
| adc_data | input | 16 | ADC sample word |
| dac_valid | output | 1 | DAC word available |
| dac_ready | input | 1 | DAC word taken |
| dac_data | output | 16 | DAC word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |

## Verification
Register writes and DAC words become visible on the same rising edge that samples bit 0 of the frame, which is 15 edges after the `fs_in` edge. `fs_out` and the output MSB appear one edge after the ADC transfer, and output bit n appears 16 − n edges after it. The bench drives inputs on falling edges and samples outputs on falling edges. After each frame it waits for the falling edge that follows the edge the result is due on, so every check lands in a cycle where the result is already settled.

// File: rtl/csp_pkg.sv
package csp_pkg;

  typedef enum logic [1:0] {
    MODE_CTRL  = 2'd0,
    MODE_DATA  = 2'd1,
    MODE_MIXED = 2'd2
  } csp_mode_e;

  // bit 0 enables sample traffic, bit 1 adds the frame-type flag on top of it
  function automatic csp_mode_e mode_decode(input logic [1:0] bits);
    if (!bits[0])     return MODE_CTRL;
    else if (bits[1]) return MODE_MIXED;
    else              return MODE_DATA;
  endfunction

endpackage

// File: rtl/csp_bit_counter.sv
module csp_bit_counter #(
  parameter int LAST = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic wrap
);
  localparam int CW = $clog2(LAST + 1);

  logic [CW-1:0] cnt;

  assign wrap = active && (cnt == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (wrap) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csp_reg_bank.sv
module csp_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_we,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [REG_W-1:0]  s_wdata,
  input  logic              p_we,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [REG_W-1:0]  p_wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [REG_W-1:0]  ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [REG_W-1:0]  rb_data,
  output logic [1:0]        mode_bits
);
  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (s_we && s_addr == ADDR_W'(g))
        regs[g] <= s_wdata;          // serial side wins a same-edge collision
      else if (p_we && p_addr == ADDR_W'(g))
        regs[g] <= p_wdata;
    end
  end

  assign ra_data   = regs[ra_addr];
  assign rb_data   = regs[rb_addr];
  assign mode_bits = regs[0][1:0];
endmodule

// File: rtl/csp_frame_codec.sv
module csp_frame_codec
  import csp_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 3
) (
  input  csp_mode_e          mode,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               rx_done,
  input  logic [FRAME_W-1:0] adc_data,
  input  logic               rd_pend,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [REG_W-1:0]   rd_data,
  output logic               ctl_we,
  output logic               ctl_rd,
  output logic [ADDR_W-1:0]  ctl_addr,
  output logic [REG_W-1:0]   ctl_wdata,
  output logic               dac_upd,
  output logic [FRAME_W-1:0] dac_word,
  output logic [FRAME_W-1:0] tx_word
);
  localparam int FLAG = FRAME_W - 1;
  localparam int RW   = FRAME_W - 2;

  logic ctl_hit;
  logic [FRAME_W-1:0] resp;

  always_comb begin
    ctl_hit  = 1'b0;
    dac_upd  = 1'b0;
    dac_word = rx_word;
    unique case (mode)
      MODE_CTRL: ctl_hit = rx_word[FLAG];
      MODE_DATA: dac_upd = rx_done;
      MODE_MIXED: begin
        ctl_hit  = rx_word[FLAG];
        dac_upd  = rx_done && !rx_word[FLAG];
        dac_word = {rx_word[FRAME_W-2:0], 1'b0};
      end
      default: ctl_hit = 1'b0;
    endcase
  end

  assign ctl_we    = rx_done && ctl_hit && !rx_word[RW];
  assign ctl_rd    = rx_done && ctl_hit &&  rx_word[RW];
  assign ctl_addr  = rx_word[REG_W +: ADDR_W];
  assign ctl_wdata = rx_word[REG_W-1:0];

  always_comb begin
    resp                    = '0;
    resp[FLAG]              = 1'b1;
    resp[RW]                = 1'b1;
    resp[REG_W +: ADDR_W]   = rd_addr;
    resp[REG_W-1:0]         = rd_data;
  end

  always_comb begin
    if (rd_pend) tx_word = resp;
    else begin
      unique case (mode)
        MODE_DATA:  tx_word = adc_data;
        MODE_MIXED: tx_word = {1'b0, adc_data[FRAME_W-1:1]};
        default:    tx_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter  int FRAME_W  = 16,
  parameter  int NUM_REGS = 8,
  parameter  int REG_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_in,
  input  logic               sd_in,
  output logic               fs_out,
  output logic               sd_out,
  input  logic               adc_valid,
  output logic               adc_ready,
  input  logic [FRAME_W-1:0] adc_data,
  output logic               dac_valid,
  input  logic               dac_ready,
  output logic [FRAME_W-1:0] dac_data,
  input  logic               cfg_wr,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata
);
  logic               load;
  logic               rx_active, rx_wrap, rx_done;
  logic               tx_active, tx_wrap;
  logic               shift_en;
  logic [FRAME_W-1:0] sreg, rx_word, tx_word;
  logic [1:0]         mode_bits;
  csp_mode_e          mode_sel;
  logic               rd_pend_q;
  logic [ADDR_W-1:0]  rd_addr_q;
  logic [REG_W-1:0]   rd_data;
  logic               ctl_we, ctl_rd, dac_upd;
  logic [ADDR_W-1:0]  ctl_addr;
  logic [REG_W-1:0]   ctl_wdata;
  logic [FRAME_W-1:0] dac_word;
  logic               ready_q, fs_q;

  assign load      = adc_valid && ready_q;
  assign adc_ready = ready_q;
  assign mode_sel  = mode_decode(mode_bits);

  // receive framing: starts on fs_in, ends at bit 0; a sample load kills it
  csp_bit_counter #(.LAST(FRAME_W - 2)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n),
    .start(fs_in && !load), .abort(load),
    .active(rx_active), .wrap(rx_wrap)
  );

  // transmit framing: one full word after every sample load
  csp_bit_counter #(.LAST(FRAME_W - 1)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n),
    .start(load), .abort(1'b0),
    .active(tx_active), .wrap(tx_wrap)
  );

  assign rx_done  = rx_wrap && !load;
  assign shift_en = fs_in || rx_active || tx_active;
  assign rx_word  = {sreg[FRAME_W-2:0], sd_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (load)     sreg <= tx_word;
    else if (shift_en) sreg <= rx_word;
  end

  assign sd_out = sreg[FRAME_W-1];
  assign fs_out = fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      fs_q    <= load;
      ready_q <= 1'b1;
    end
  end

  csp_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .s_we(ctl_we), .s_addr(ctl_addr), .s_wdata(ctl_wdata),
    .p_we(cfg_wr), .p_addr(cfg_addr), .p_wdata(cfg_wdata),
    .ra_addr(cfg_addr), .ra_data(cfg_rdata),
    .rb_addr(rd_addr_q), .rb_data(rd_data),
    .mode_bits(mode_bits)
  );

  csp_frame_codec #(.FRAME_W(FRAME_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_codec (
    .mode(mode_sel), .rx_word(rx_word), .rx_done(rx_done),
    .adc_data(adc_data), .rd_pend(rd_pend_q), .rd_addr(rd_addr_q), .rd_data(rd_data),
    .ctl_we(ctl_we), .ctl_rd(ctl_rd), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .dac_upd(dac_upd), .dac_word(dac_word), .tx_word(tx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else if (load) begin
      rd_pend_q <= 1'b0;
    end else if (ctl_rd) begin
      rd_pend_q <= 1'b1;
      rd_addr_q <= ctl_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_valid <= 1'b0;
      dac_data  <= '0;
    end else if (dac_upd) begin
      dac_valid <= 1'b1;
      dac_data  <= dac_word;
    end else if (dac_ready) begin
      dac_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csp_sva.sv
module csp_sva #(
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               adc_valid,
  input logic               adc_ready,
  input logic [FRAME_W-1:0] adc_data,
  input logic               fs_out,
  input logic               sd_out,
  input logic               dac_valid,
  input logic               dac_ready,
  input logic [1:0]         mode,
  input logic               rd_pend
);
  logic take;
  assign take = adc_valid && adc_ready;

  assert_fs_follows_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> fs_out);

  assert_fs_needs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |-> $past(take));

  assert_fs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_out && !take) |=> !fs_out);

  assert_data_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 2'd1 && !rd_pend) |=> (sd_out == $past(adc_data[FRAME_W-1])));

  assert_dac_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && !dac_ready) |=> dac_valid);
endmodule

bind codec_serial_port csp_sva #(.FRAME_W(FRAME_W)) u_csp_sva (
  .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_ready(adc_ready),
  .adc_data(adc_data), .fs_out(fs_out), .sd_out(sd_out),
  .dac_valid(dac_valid), .dac_ready(dac_ready),
  .mode(mode_sel), .rd_pend(rd_pend_q)
);

// File: tb/tb_codec_serial_port.sv
`timescale 1ns/1ps
module tb_codec_serial_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic fs_in = 0, sd_in = 0, adc_valid = 0, dac_ready = 0, cfg_wr = 0;
  logic [15:0] adc_data = '0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic fs_out, sd_out, adc_ready, dac_valid;
  logic [15:0] dac_data;
  logic [7:0]  cfg_rdata;

  codec_serial_port dut (
    .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .sd_in(sd_in), .fs_out(fs_out), .sd_out(sd_out),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .adc_data(adc_data),
    .dac_valid(dac_valid), .dac_ready(dac_ready), .dac_data(dac_data),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int total = 0, bad = 0;
  logic [7:0] mreg [8];
  bit         m_rdp = 0;
  logic [2:0] m_ra = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mmode();
    if (!mreg[0][0]) return 0;
    return mreg[0][1] ? 2 : 1;
  endfunction

  function automatic logic [15:0] exp_tx(input logic [15:0] adc);
    if (m_rdp) return {2'b11, 3'b000, m_ra, mreg[m_ra]};
    case (mmode())
      1:       return adc;
      2:       return {1'b0, adc[15:1]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_rx(input logic [15:0] w, output bit upd, output logic [15:0] dw);
    int md = mmode();
    upd = (md == 1) || (md == 2 && !w[15]);
    dw  = (md == 1) ? w : {w[14:0], 1'b0};
    if (md != 1 && w[15]) begin
      if (w[14]) begin m_rdp = 1; m_ra = w[10:8]; end
      else mreg[w[10:8]] = w[7:0];
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input bit pw = 0,
                            input logic [2:0] pa = 0, input logic [7:0] pd = 0);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      fs_in = (i == 15);
      sd_in = w[i];
      if (i == 0) begin cfg_wr = pw; cfg_addr = pa; cfg_wdata = pd; end
    end
    @(negedge clk);
    fs_in = 0; sd_in = 0; cfg_wr = 0;
  endtask

  // sample load, optional frame starting one edge later; returns the shifted-out word
  task automatic xfer(input logic [15:0] aw, input bit do_rx, input logic [15:0] rw,
                      output logic [15:0] got, output bit fs_ok);
    @(negedge clk);
    adc_valid = 1; adc_data = aw;
    @(negedge clk);
    adc_valid = 0;
    fs_ok = 1;
    for (int j = 0; j < 16; j++) begin
      if (j > 0) @(negedge clk);
      got[15-j] = sd_out;
      if (j == 0) fs_ok = fs_out;
      else if (fs_out) fs_ok = 0;
      fs_in = do_rx && (j == 0);
      sd_in = do_rx ? rw[15-j] : 1'b0;
    end
    @(negedge clk);
    fs_in = 0; sd_in = 0;
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    mreg[a] = d;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic dac_take();
    @(negedge clk); dac_ready = 1;
    @(negedge clk); dac_ready = 0;
  endtask

  task automatic check_regs(input string req);
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      cfg_read(3'(a), d);
      chk(req, d, mreg[a]);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] got, w, a, dw;
    bit fsok, upd;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) mreg[i] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fs_out", fs_out, 0);
    chk("R1 sd_out", sd_out, 0);
    chk("R1 dac_valid", dac_valid, 0);
    chk("R1 adc_ready", adc_ready, 1);
    check_regs("R1 regs");

    // R2 R3 serial writes in control mode
    for (int i = 0; i < 6; i++) begin
      w = {1'b1, 1'b0, 3'b000, 3'(1 + (i % 7)), 8'($urandom)};
      send_frame(w);
      model_rx(w, upd, dw);
    end
    check_regs("R3 write");

    // R3 flag clear ignored
    send_frame(16'h7FFF);
    chk("R3 ignore dac", dac_valid, 0);
    check_regs("R3 ignore regs");

    // R4 read response, then empty word
    w = 16'hC200;
    send_frame(w);
    model_rx(w, upd, dw);
    a = 16'($urandom);
    xfer(a, 0, 0, got, fsok);
    chk("R4 read resp", got, {2'b11, 3'b000, 3'd2, mreg[2]});
    chk("R8 fs_out frame", fsok, 1);
    m_rdp = 0;
    xfer(16'($urandom), 0, 0, got, fsok);
    chk("R4 ctrl empty", got, 16'h0000);

    // R11 collision: serial write wins
    w = {8'b1000_0011, 8'hA5};
    send_frame(w, 1, 3'd3, 8'h3C);
    model_rx(w, upd, dw);
    check_regs("R11 collide");

    // R5 R6 data mode with full-duplex frames
    cfg_write(3'd0, 8'h01);
    for (int i = 0; i < 20; i++) begin
      a = 16'($urandom); w = 16'($urandom);
      if (i == 0) begin a = 16'hFFFF; w = 16'h0000; end
      if (i == 1) begin a = 16'h0000; w = 16'hFFFF; end
      xfer(a, 1, w, got, fsok);
      chk("R6 tx word", got, exp_tx(a));
      chk("R8 fs_out", fsok, 1);
      m_rdp = 0;
      model_rx(w, upd, dw);
      chk("R9 duplex dac_valid", dac_valid, 1);
      chk("R6 dac word", dac_data, dw);
      dac_take();
      chk("R10 dac taken", dac_valid, 0);
    end

    // R10 hold and overwrite
    send_frame(16'h1234);
    send_frame(16'hBEEF);
    repeat (3) @(negedge clk);
    chk("R10 hold valid", dac_valid, 1);
    chk("R10 overwrite", dac_data, 16'hBEEF);
    dac_take();
    chk("R10 take", dac_valid, 0);

    // R9 partial frame aborted by sample load
    for (int i = 15; i >= 8; i--) begin
      @(negedge clk); fs_in = (i == 15); sd_in = 1'($urandom);
    end
    a = 16'($urandom);
    xfer(a, 0, 0, got, fsok);
    chk("R9 abort tx", got, a);
    chk("R9 abort dac", dac_valid, 0);

    // R9 fs_in on the load edge is ignored
    @(negedge clk);
    adc_valid = 1; adc_data = 16'h5555; fs_in = 1; sd_in = 1;
    @(negedge clk);
    adc_valid = 0; fs_in = 0;
    repeat (17) begin @(negedge clk); sd_in = 1'($urandom); end
    sd_in = 0;
    chk("R9 same edge", dac_valid, 0);

    // R7 mixed mode with random control/data frames
    cfg_write(3'd0, 8'h03);
    for (int i = 0; i < 24; i++) begin
      a = 16'($urandom); w = 16'($urandom);
      if (w[15]) w[10:8] = 3'(1 + (w[10:8] % 7));
      xfer(a, 1, w, got, fsok);
      chk("R7 tx word", got, exp_tx(a));
      m_rdp = 0;
      model_rx(w, upd, dw);
      chk("R7 dac valid", dac_valid, 32'(upd));
      if (upd) begin
        chk("R7 dac word", dac_data, dw);
        dac_take();
      end
    end
    check_regs("R7 regs");

    // R5 serial write of register 0 returns to control mode
    w = 16'h8000;
    send_frame(w);
    model_rx(w, upd, dw);
    send_frame(16'h1357);
    chk("R5 back to ctrl", dac_valid, 0);
    xfer(16'hFFFF, 0, 0, got, fsok);
    chk("R5 ctrl tx", got, exp_tx(16'hFFFF));

    finish_run();
  end
endmodule